// File: doc/BRIEF.md
# Interrupt Controller Mode and Base Register

This block is the mode and placement register of a local interrupt controller. It holds an enable bit, an extended-mode bit, a boot-processor flag and the physical base address of the controller's 4 KiB register window. Every write through the 64-bit configuration port is checked against the three legal modes and the permitted moves between them: disabled, legacy-enabled and extended-enabled. A write that is not allowed is dropped, and the block raises a one-cycle fault strobe in its place.

The current mode controls two other things. The first is the memory-mapped window. It answers only in legacy mode, and only at the programmed base. The second is the identifier register. It is writable in legacy mode. In extended mode it is read-only, and a write attempt faults. The window exposes the identifier, a fixed version byte and the task priority. The register contents behind the window, other than these three, are not part of this block.

Top module: `intc_mode_base`

## Requirements
- R1: After reset the block is legacy-enabled. `cfgRdData` reads 0x00000000_FEE00900, which is base 0xFEE00000 with enable bit 11 and boot bit 8 set. Only `modeLegacy` is high and both fault strobes are low.
- R2: A write with bit 10 (extended) set and bit 11 (enable) clear always faults.
- R3: From extended mode, a write that selects legacy mode (bit 11 = 1, bit 10 = 0) faults. A write that selects disabled (bit 11 = 0, bit 10 = 0) is accepted.
- R4: From disabled, a write that selects extended mode (bits 11 and 10 both set) faults. A write that selects legacy is accepted, and so is a move from legacy to extended.
- R5: A write faults if it sets any bit other than bit 8, bit 10, bit 11 and the base bits 12 to MAX_PHYS-1. This includes bit 0, bit 9 and every bit at or above MAX_PHYS (default 36).
- R6: The fault strobe is high for exactly the one cycle after a faulting write, and a faulting write leaves `cfgRdData` unchanged. An accepted write appears on `cfgRdData` in the cycle after the write.
- R7: When enabled in legacy mode, the window is claimed only where `winAddr` bits MAX_PHYS-1 to 12 equal the stored base. After a base change, reads at the new base hit and reads at the old base are unclaimed.
- R8: In disabled and in extended mode the window is unclaimed. Reads return 0xFFFFFFFF and writes have no effect.
- R9: Claimed window reads return the following. Offset 0x020 gives the identifier in bits 31:24. Offset 0x030 gives the version byte (default 0x14). Offset 0x080 gives `prioIn` shifted left by 4. Every other offset returns zero.
- R10: In legacy mode the identifier is loaded by `idWrEn` from `idWrByte`, or by a window write at offset 0x020 from `winWrByte`. In extended mode `idWrEn` faults on `idFault` in the next cycle and leaves the identifier unchanged. In disabled mode `idWrEn` is ignored and does not fault.
- R11: `idRdData` depends on the mode. In legacy mode it holds the identifier in bits 31:24. In extended mode it holds the identifier in bits 7:0. When disabled it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgWrData | input | 64 | Configuration write value |
| cfgRdData | output | 64 | Stored configuration value |
| cfgFault | output | 1 | Pulse: previous configuration write was rejected |
| idWrEn | input | 1 | Direct identifier write request |
| idWrByte | input | 8 | Identifier value for a direct write |
| idRdData | output | 32 | Identifier in the current mode's format |
| idFault | output | 1 | Pulse: previous identifier write was rejected |
| winAddr | input | MAX_PHYS | Physical address of a window access |
| winWrEn | input | 1 | Window write request |
| winWrByte | input | 8 | Top byte of the 32-bit window write |
| winRdData | output | 32 | Window read data, all ones when unclaimed |
| prioIn | input | 4 | Current task priority |
| modeDisabled | output | 1 | Controller disabled |
| modeLegacy | output | 1 | Legacy mode enabled |
| modeExtended | output | 1 | Extended mode enabled |

## Verification
The hardest cases to reach are the transitions that are only illegal from a particular mode. Extended-to-legacy can only be tried after a legal pass through legacy into extended mode. Disabled-to-extended needs a legal exit from extended mode first. The directed part of the bench walks this chain of legal steps in order. A seeded random sequence then mixes all four mode codes with random bases and occasional reserved bits, so every pairing of current and requested mode is hit many times. A second hard case is showing that identifier and window writes in disabled or extended mode have no effect. The bench does this by returning to legacy mode and reading the identifier back.

// File: rtl/intc_mode_pkg.sv
package intc_mode_pkg;

  // Field positions inside the 64-bit configuration word
  localparam int ENABLE_BIT = 11;
  localparam int EXTEND_BIT = 10;
  localparam int BOOT_BIT   = 8;
  localparam int BASE_LSB   = 12;

  // Window offsets decoded by the datapath
  localparam logic [11:0] OFS_ID   = 12'h020;
  localparam logic [11:0] OFS_VER  = 12'h030;
  localparam logic [11:0] OFS_PRIO = 12'h080;

  // Legal modes, encoded as {enable, extended}
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } modeSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgCommit;
    logic cfgFault;
    logic idPortLoad;
    logic idWinLoad;
    logic idFault;
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_mode_ctrl.sv
module intc_mode_ctrl
  import intc_mode_pkg::*;
#(
  parameter int MAX_PHYS = 36
) (
  input  logic                           curEn,
  input  logic                           curExt,
  input  logic                           cfgWrEn,
  input  logic [63:0]                    cfgWrData,
  input  logic                           idWrEn,
  input  logic                           winWrEn,
  input  logic                           winHit,
  input  logic [11:0]                    winOfs,
  output ctrlStrobe_t                    strobe,
  output logic                           newEn,
  output logic                           newExt,
  output logic                           newBoot,
  output logic [MAX_PHYS-BASE_LSB-1:0]   newBase
);

  localparam int BASE_W = MAX_PHYS - BASE_LSB;

  function automatic logic [63:0] buildLegalMask();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i == ENABLE_BIT) || (i == EXTEND_BIT) || (i == BOOT_BIT) ||
             (i >= BASE_LSB && i < MAX_PHYS);
    end
    return m;
  endfunction

  localparam logic [63:0] LEGAL_MASK = buildLegalMask();

  logic     reservedHit;
  logic     badCombo;
  logic     transitionOk;
  logic     illegal;
  modeSel_t curMode;

  assign newEn   = cfgWrData[ENABLE_BIT];
  assign newExt  = cfgWrData[EXTEND_BIT];
  assign newBoot = cfgWrData[BOOT_BIT];
  assign newBase = cfgWrData[MAX_PHYS-1:BASE_LSB];

  assign reservedHit = |(cfgWrData & ~LEGAL_MASK);
  assign badCombo    = newExt & ~newEn;
  assign curMode     = modeSel_t'({curEn, curExt});

  // Transition table over the legal modes
  always_comb begin
    transitionOk = 1'b1;
    unique case (curMode)
      MODE_EXT:    transitionOk = !(newEn && !newExt); // extended may only go to off
      MODE_OFF:    transitionOk = !(newEn && newExt);  // off must pass through legacy
      MODE_LEGACY: transitionOk = 1'b1;
      default:     transitionOk = 1'b1;
    endcase
  end

  assign illegal = reservedHit | badCombo | ~transitionOk;

  always_comb begin
    strobe            = '0;
    strobe.cfgCommit  = cfgWrEn & ~illegal;
    strobe.cfgFault   = cfgWrEn & illegal;
    strobe.idPortLoad = idWrEn & (curMode == MODE_LEGACY);
    strobe.idFault    = idWrEn & (curMode == MODE_EXT);
    strobe.idWinLoad  = winWrEn & winHit & (winOfs == OFS_ID);
  end

  logic unusedBaseW;
  assign unusedBaseW = ^BASE_W[0];

endmodule

// File: rtl/intc_mode_dp.sv
module intc_mode_dp
  import intc_mode_pkg::*;
#(
  parameter int          MAX_PHYS   = 36,
  parameter logic [63:0] BASE_RESET = 64'h0000_0000_FEE0_0000,
  parameter logic        BOOT_RESET = 1'b1,
  parameter logic [7:0]  INIT_ID    = 8'h00,
  parameter logic [7:0]  VERSION    = 8'h14
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic                         newEn,
  input  logic                         newExt,
  input  logic                         newBoot,
  input  logic [MAX_PHYS-BASE_LSB-1:0] newBase,
  input  logic [7:0]                   idWrByte,
  input  logic [MAX_PHYS-1:0]          winAddr,
  input  logic [7:0]                   winWrByte,
  input  logic [3:0]                   prioIn,
  output logic                         curEn,
  output logic                         curExt,
  output logic                         winHit,
  output logic [63:0]                  cfgRdData,
  output logic                         cfgFault,
  output logic [31:0]                  idRdData,
  output logic                         idFault,
  output logic [31:0]                  winRdData,
  output logic                         modeDisabled,
  output logic                         modeLegacy,
  output logic                         modeExtended
);

  localparam int BASE_W = MAX_PHYS - BASE_LSB;

  logic              enQ, extQ, bootQ;
  logic [BASE_W-1:0] baseQ;
  logic [7:0]        idQ;
  logic              cfgFaultQ, idFaultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ       <= 1'b1;
      extQ      <= 1'b0;
      bootQ     <= BOOT_RESET;
      baseQ     <= BASE_RESET[MAX_PHYS-1:BASE_LSB];
      cfgFaultQ <= 1'b0;
    end else begin
      cfgFaultQ <= strobe.cfgFault;
      if (strobe.cfgCommit) begin
        enQ   <= newEn;
        extQ  <= newExt;
        bootQ <= newBoot;
        baseQ <= newBase;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ      <= INIT_ID;
      idFaultQ <= 1'b0;
    end else begin
      idFaultQ <= strobe.idFault;
      if (strobe.idPortLoad)     idQ <= idWrByte;
      else if (strobe.idWinLoad) idQ <= winWrByte;
    end
  end

  assign curEn        = enQ;
  assign curExt       = extQ;
  assign cfgFault     = cfgFaultQ;
  assign idFault      = idFaultQ;
  assign modeDisabled = ~enQ;
  assign modeLegacy   = enQ & ~extQ;
  assign modeExtended = enQ & extQ;

  always_comb begin
    cfgRdData                         = '0;
    cfgRdData[MAX_PHYS-1:BASE_LSB]    = baseQ;
    cfgRdData[ENABLE_BIT]             = enQ;
    cfgRdData[EXTEND_BIT]             = extQ;
    cfgRdData[BOOT_BIT]               = bootQ;
  end

  always_comb begin
    if (modeLegacy)        idRdData = {idQ, 24'h0};
    else if (modeExtended) idRdData = {24'h0, idQ};
    else                   idRdData = '0;
  end

  assign winHit = modeLegacy & (winAddr[MAX_PHYS-1:BASE_LSB] == baseQ);

  always_comb begin
    if (!winHit) begin
      winRdData = '1;
    end else begin
      unique case (winAddr[BASE_LSB-1:0])
        OFS_ID:   winRdData = {idQ, 24'h0};
        OFS_VER:  winRdData = {24'h0, VERSION};
        OFS_PRIO: winRdData = {24'h0, prioIn, 4'h0};
        default:  winRdData = '0;
      endcase
    end
  end

  AST_NO_EXT_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rstN)
    !(extQ && !enQ)); // R2
  AST_FAULT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgFault |=> $stable({enQ, extQ, bootQ, baseQ})); // R6
  AST_EXT_EXITS_TO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extQ) |-> !enQ); // R3
  AST_EXT_ENTERED_FROM_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extQ) |-> $past(enQ)); // R4
  AST_UNCLAIMED_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    !modeLegacy |-> winRdData == 32'hFFFF_FFFF); // R8
  AST_EXT_ID_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (extQ && enQ && $past(extQ)) |-> $stable(idQ)); // R10

endmodule

// File: rtl/intc_mode_base.sv
module intc_mode_base
  import intc_mode_pkg::*;
#(
  parameter int          MAX_PHYS   = 36,
  parameter logic [63:0] BASE_RESET = 64'h0000_0000_FEE0_0000,
  parameter logic        BOOT_RESET = 1'b1,
  parameter logic [7:0]  INIT_ID    = 8'h00,
  parameter logic [7:0]  VERSION    = 8'h14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [63:0]         cfgWrData,
  output logic [63:0]         cfgRdData,
  output logic                cfgFault,
  input  logic                idWrEn,
  input  logic [7:0]          idWrByte,
  output logic [31:0]         idRdData,
  output logic                idFault,
  input  logic [MAX_PHYS-1:0] winAddr,
  input  logic                winWrEn,
  input  logic [7:0]          winWrByte,
  output logic [31:0]         winRdData,
  input  logic [3:0]          prioIn,
  output logic                modeDisabled,
  output logic                modeLegacy,
  output logic                modeExtended
);

  localparam int BASE_W = MAX_PHYS - BASE_LSB;

  ctrlStrobe_t       strobe;
  logic              curEn, curExt, winHit;
  logic              newEn, newExt, newBoot;
  logic [BASE_W-1:0] newBase;

  intc_mode_ctrl #(.MAX_PHYS(MAX_PHYS)) ctrl_i (
    .curEn(curEn), .curExt(curExt),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .idWrEn(idWrEn), .winWrEn(winWrEn), .winHit(winHit),
    .winOfs(winAddr[BASE_LSB-1:0]),
    .strobe(strobe), .newEn(newEn), .newExt(newExt),
    .newBoot(newBoot), .newBase(newBase)
  );

  intc_mode_dp #(
    .MAX_PHYS(MAX_PHYS), .BASE_RESET(BASE_RESET), .BOOT_RESET(BOOT_RESET),
    .INIT_ID(INIT_ID), .VERSION(VERSION)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .newEn(newEn), .newExt(newExt), .newBoot(newBoot), .newBase(newBase),
    .idWrByte(idWrByte), .winAddr(winAddr), .winWrByte(winWrByte),
    .prioIn(prioIn), .curEn(curEn), .curExt(curExt), .winHit(winHit),
    .cfgRdData(cfgRdData), .cfgFault(cfgFault),
    .idRdData(idRdData), .idFault(idFault), .winRdData(winRdData),
    .modeDisabled(modeDisabled), .modeLegacy(modeLegacy),
    .modeExtended(modeExtended)
  );

endmodule

// File: tb/intc_mode_base_tb.sv
module intc_mode_base_tb_top;

  localparam int         MAX_PHYS = 36;
  localparam logic [7:0] VER      = 8'h14;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic                rstN = 1'b0;
  logic                cfgWrEn = 1'b0;
  logic [63:0]         cfgWrData = '0;
  logic [63:0]         cfgRdData;
  logic                cfgFault;
  logic                idWrEn = 1'b0;
  logic [7:0]          idWrByte = '0;
  logic [31:0]         idRdData;
  logic                idFault;
  logic [MAX_PHYS-1:0] winAddr = '0;
  logic                winWrEn = 1'b0;
  logic [7:0]          winWrByte = '0;
  logic [31:0]         winRdData;
  logic [3:0]          prioIn = '0;
  logic                modeDisabled, modeLegacy, modeExtended;

  intc_mode_base #(.MAX_PHYS(MAX_PHYS), .VERSION(VER)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cfgFault(cfgFault), .idWrEn(idWrEn),
    .idWrByte(idWrByte), .idRdData(idRdData), .idFault(idFault),
    .winAddr(winAddr), .winWrEn(winWrEn), .winWrByte(winWrByte),
    .winRdData(winRdData), .prioIn(prioIn), .modeDisabled(modeDisabled),
    .modeLegacy(modeLegacy), .modeExtended(modeExtended)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [63:0] model  = 64'h0000_0000_FEE0_0900;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isIllegal(input logic [63:0] cur, input logic [63:0] w);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < 64; i++)
      if (w[i] && !(i == 8 || i == 10 || i == 11 || (i >= 12 && i < MAX_PHYS))) bad = 1'b1;
    if (w[10] && !w[11]) bad = 1'b1;
    if (cur[11] && cur[10] && w[11] && !w[10]) bad = 1'b1;
    if (!cur[11] && w[11] && w[10]) bad = 1'b1;
    return bad;
  endfunction

  task automatic checkModes(input string req);
    logic [2:0] exp;
    exp = {!model[11], model[11] && !model[10], model[11] && model[10]};
    check({modeDisabled, modeLegacy, modeExtended} == exp, req,
          {modeDisabled, modeLegacy, modeExtended}, exp);
  endtask

  task automatic cfgWrite(input logic [63:0] w, input string req);
    bit expF;
    expF = isIllegal(model, w);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = w;
    @(negedge clk); cfgWrEn = 1'b0;
    if (!expF) model = w;
    check(cfgFault == expF, req, cfgFault, expF);
    check(cfgRdData == model, req, cfgRdData, model);
  endtask

  task automatic winRead(input logic [MAX_PHYS-1:0] a, input logic [31:0] exp,
                         input string req);
    @(negedge clk); winAddr = a; #1;
    check(winRdData == exp, req, winRdData, exp);
  endtask

  task automatic winWrite(input logic [MAX_PHYS-1:0] a, input logic [7:0] b);
    @(negedge clk); winAddr = a; winWrByte = b; winWrEn = 1'b1;
    @(negedge clk); winWrEn = 1'b0;
  endtask

  task automatic idWrite(input logic [7:0] b, input bit expF, input string req);
    @(negedge clk); idWrEn = 1'b1; idWrByte = b;
    @(negedge clk); idWrEn = 1'b0;
    check(idFault == expF, req, idFault, expF);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfgRdData == 64'hFEE0_0900, "R1", cfgRdData, 64'hFEE0_0900);
    checkModes("R1");
    check({cfgFault, idFault} == 2'b00, "R1", {cfgFault, idFault}, 0);

    // R9 window contents
    prioIn = 4'hA;
    winRead(36'h0_FEE0_0030, {24'h0, VER}, "R9");
    winRead(36'h0_FEE0_0080, 32'h0000_00A0, "R9");
    winRead(36'h0_FEE0_0020, 32'h0, "R9");
    winRead(36'h0_FEE0_0040, 32'h0, "R9");

    // R10 / R11 legacy identifier
    idWrite(8'h05, 1'b0, "R10");
    check(idRdData == 32'h0500_0000, "R11", idRdData, 32'h0500_0000);
    winRead(36'h0_FEE0_0020, 32'h0500_0000, "R10");
    winWrite(36'h0_FEE0_0020, 8'h07);
    check(idRdData == 32'h0700_0000, "R10", idRdData, 32'h0700_0000);

    // R4 legacy to extended; R11, R8, R10 in extended mode
    cfgWrite(64'hFEE0_0D00, "R4");
    checkModes("R4");
    check(idRdData == 32'h0000_0007, "R11", idRdData, 32'h7);
    winRead(36'h0_FEE0_0030, 32'hFFFF_FFFF, "R8");
    idWrite(8'h09, 1'b1, "R10");
    check(idRdData == 32'h0000_0007, "R10", idRdData, 32'h7);
    @(negedge clk);
    check(idFault == 1'b0, "R10", idFault, 0);

    // R3 extended exits
    cfgWrite(64'hFEE0_0900, "R3");
    checkModes("R3");
    cfgWrite(64'hFEE0_0100, "R3");
    checkModes("R3");

    // R8 / R10 / R11 disabled
    winRead(36'h0_FEE0_0020, 32'hFFFF_FFFF, "R8");
    winWrite(36'h0_FEE0_0020, 8'h33);
    idWrite(8'h44, 1'b0, "R10");
    check(idRdData == 32'h0, "R11", idRdData, 0);

    // R2, R4 from disabled
    cfgWrite(64'hFEE0_0500, "R2");
    cfgWrite(64'hFEE0_0D00, "R4");
    checkModes("R4");
    cfgWrite(64'hFEE0_0900, "R4");
    check(idRdData == 32'h0700_0000, "R8", idRdData, 32'h0700_0000);

    // R5 reserved bits, R6 pulse width
    cfgWrite(64'hFEE0_0901, "R5");
    @(negedge clk);
    check(cfgFault == 1'b0, "R6", cfgFault, 0);
    cfgWrite(64'hFEE0_0900 | (64'h1 << MAX_PHYS), "R5");
    cfgWrite(64'hFEE0_0900 | (64'h1 << 63), "R5");
    cfgWrite(64'hFEE0_0B00, "R5");

    // R7 relocation
    cfgWrite(64'hFED4_0900, "R7");
    winRead(36'h0_FED4_0030, {24'h0, VER}, "R7");
    winRead(36'h0_FEE0_0030, 32'hFFFF_FFFF, "R7");
    winWrite(36'h0_FED4_0020, 8'h11);
    check(idRdData == 32'h1100_0000, "R7", idRdData, 32'h1100_0000);

    // Random mix, R2-R7
    for (int n = 0; n < 400; n++) begin
      logic [63:0] w;
      logic [1:0]  md;
      w = '0;
      md = 2'($urandom_range(0, 3));
      w[11] = md[1];
      w[10] = md[0];
      w[8]  = 1'($urandom_range(0, 1));
      w[MAX_PHYS-1:12] = 24'($urandom);
      if ($urandom_range(0, 5) == 0) w[$urandom_range(0, 63)] = 1'b1;
      cfgWrite(w, "R6");
      checkModes("R3");
      winRead({model[MAX_PHYS-1:12], 12'h030},
              (model[11] && !model[10]) ? {24'h0, VER} : 32'hFFFF_FFFF, "R7");
    end

    finishRun();
  end

endmodule